// File: doc/BRIEF.md
# Immediate Word Serializer with Byte-Local Ordering

The block takes a 32-bit word on a load strobe and sends it out in pieces of 1, 2 or 4 bits, one piece for each pulse of a rate-enable tick. It is meant to be the serial back end of a larger output engine. That engine supplies a whole word and a mode, and the block then paces the word out at the rate the tick sets. Busy and done flags tell the engine when it may supply the next word.

Two orderings are available. In the linear ordering, pieces leave the word from the bottom bit upward across all 32 bits. In the byte-local ordering, the four bytes still leave lowest byte first. Inside each byte, however, the pieces leave from the top of the byte downward. Pieces never cross a byte boundary. A full word therefore never comes out in MSB-first order.

The mode input carries the unit width in its low three bits as a plain number of bits, and the ordering flag at bit 16. Every other mode bit is ignored. The word and the mode are captured at the load and stay fixed until the last unit has left.

Top module: `imm_word_serializer`

## Requirements
- R1: After reset the block is idle, with `ser_o` = 0 and `valid_o`, `busy_o` and `done_o` all low.
- R2: When `mode_i[2:0]` = 1 and `mode_i[16]` = 0, step k (k = 0..31) outputs bit k of the loaded word on `ser_o[0]`.
- R3: When `mode_i[2:0]` = 1 and `mode_i[16]` = 1, step k outputs bit 8*(k/8) + 7 - (k mod 8) of the loaded word. Bytes go lowest first, and the bits within each byte go highest first.
- R4: When `mode_i[2:0]` is 2 or 4 (width w) and `mode_i[16]` = 0, step k outputs word bits [k*w + w-1 : k*w] on `ser_o[w-1:0]`. The unused upper bits of `ser_o` read 0.
- R5: When the width w is 2 or 4 and `mode_i[16]` = 1, step k outputs the unit at bit offset 8*b + (8/w - 1 - j)*w, where b = k/(8/w) and j = k mod (8/w). No unit crosses a byte boundary.
- R6: Each tick while busy emits exactly one unit. `valid_o` is high only in the cycle after such a tick. Without a tick the word does not advance. `ser_o` holds its value while `valid_o` is low, and a tick while idle has no effect.
- R7: A word takes 32/w steps. `busy_o` is high from the cycle after an accepted load until the last unit appears, and it falls in the same cycle as that last unit. `done_o` is high for exactly the one cycle after the last unit.
- R8: A load while busy is ignored. Changes to `data_i` or `mode_i` after an accepted load do not alter the word in flight.
- R9: Width codes other than 1, 2 or 4 in `mode_i[2:0]` are treated as a 1-bit unit, giving 32 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe; takes effect only when idle |
| data_i | input | 32 | Word to serialize |
| mode_i | input | 17 | [2:0] unit width in bits, [16] byte-local ordering |
| tick_i | input | 1 | Rate enable; one unit per tick while busy |
| ser_o | output | 4 | Current unit, right-aligned |
| valid_o | output | 1 | New unit on ser_o this cycle |
| busy_o | output | 1 | A word is in flight |
| done_o | output | 1 | One-cycle pulse after the last unit |

## Verification
Each word is sent in both orderings at every unit width. Asymmetric patterns such as 32'h8421F00D and single-bit words such as 32'h00000001 make the byte-local order visibly different from the linear order and from a whole-word reversal. Some runs leave idle gaps between ticks while `load_i` is held high with altered data and mode; these show that a word in flight is neither advanced nor replaced. Directed runs cover ticks while idle, the reset state and the invalid width codes 0, 3 and 7.

// File: rtl/imser_pkg.sv
package imser_pkg;

    localparam int WCODE_W = 3;

    // value equals log2 of the unit width in bits
    typedef enum logic [1:0] {
        UW_1 = 2'd0,
        UW_2 = 2'd1,
        UW_4 = 2'd2
    } unit_w_e;

    function automatic unit_w_e decode_width(input logic [WCODE_W-1:0] code);
        unit_w_e r;
        case (code)
            3'd2:    r = UW_2;
            3'd4:    r = UW_4;
            default: r = UW_1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/imser_addr.sv
module imser_addr
    import imser_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int STEP_W = $clog2(WORD_W),
    parameter int OFF_W  = $clog2(WORD_W)
) (
    input  logic [STEP_W-1:0] step_i,
    input  unit_w_e           uw_i,
    input  logic              order_i,
    output logic [OFF_W-1:0]  offset_o,
    output logic              last_o
);

    localparam int BYTE_LG = $clog2(BYTE_W);

    logic [OFF_W-1:0]   lin;
    logic [BYTE_LG-1:0] wmask;

    always_comb begin
        lin   = OFF_W'(step_i) << uw_i;
        wmask = BYTE_LG'((32'd1 << uw_i) - 32'd1);
        // mirror the unit slot inside its byte: slot ^ (BYTE_W - w)
        if (order_i) begin
            offset_o = {lin[OFF_W-1:BYTE_LG], lin[BYTE_LG-1:0] ^ ~wmask};
        end else begin
            offset_o = lin;
        end
        last_o = (step_i == STEP_W'((WORD_W >> uw_i) - 1));
    end

endmodule

// File: rtl/imser_extract.sv
module imser_extract
    import imser_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int UNIT_MAX = 4,
    parameter int OFF_W    = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0]   data_i,
    input  logic [OFF_W-1:0]    offset_i,
    input  unit_w_e             uw_i,
    output logic [UNIT_MAX-1:0] unit_o
);

    for (genvar i = 0; i < UNIT_MAX; i++) begin : g_lane
        logic [OFF_W-1:0] idx;
        assign idx       = offset_i + OFF_W'(i);
        assign unit_o[i] = (i < (1 << uw_i)) ? data_i[idx] : 1'b0;
    end

endmodule

// File: rtl/imm_word_serializer.sv
module imm_word_serializer
    import imser_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int BYTE_W    = 8,
    parameter int UNIT_MAX  = 4,
    parameter int MODE_W    = 17,
    parameter int ORDER_BIT = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                load_i,
    input  logic [WORD_W-1:0]   data_i,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic                tick_i,
    output logic [UNIT_MAX-1:0] ser_o,
    output logic                valid_o,
    output logic                busy_o,
    output logic                done_o
);

    localparam int STEP_W = $clog2(WORD_W);
    localparam int OFF_W  = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0]   data;
        unit_w_e             uw;
        logic                order;
        logic [STEP_W-1:0]   step;
        logic                busy;
        logic [UNIT_MAX-1:0] ser;
        logic                valid;
        logic                last;
        logic                done;
    } state_t;

    state_t st_d, st_q;

    logic [OFF_W-1:0]    offset;
    logic                at_last;
    logic [UNIT_MAX-1:0] unit;

    imser_addr #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W),
        .STEP_W (STEP_W),
        .OFF_W  (OFF_W)
    ) u_addr (
        .step_i   (st_q.step),
        .uw_i     (st_q.uw),
        .order_i  (st_q.order),
        .offset_o (offset),
        .last_o   (at_last)
    );

    imser_extract #(
        .WORD_W   (WORD_W),
        .UNIT_MAX (UNIT_MAX),
        .OFF_W    (OFF_W)
    ) u_extract (
        .data_i   (st_q.data),
        .offset_i (offset),
        .uw_i     (st_q.uw),
        .unit_o   (unit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.last  = 1'b0;
        st_d.done  = st_q.valid && st_q.last;
        if (!st_q.busy) begin
            if (load_i) begin
                st_d.data  = data_i;
                st_d.uw    = decode_width(mode_i[WCODE_W-1:0]);
                st_d.order = mode_i[ORDER_BIT];
                st_d.step  = '0;
                st_d.busy  = 1'b1;
            end
        end else if (tick_i) begin
            st_d.ser   = unit;
            st_d.valid = 1'b1;
            st_d.last  = at_last;
            if (at_last) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_o   = st_q.ser;
    assign valid_o = st_q.valid;
    assign busy_o  = st_q.busy;
    assign done_o  = st_q.done;

endmodule

// File: rtl/imser_check.sv
module imser_check #(
    parameter int UNIT_MAX = 4
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                load_i,
    input logic                tick_i,
    input logic [UNIT_MAX-1:0] ser_o,
    input logic                valid_o,
    input logic                busy_o,
    input logic                done_o
);

    assert_valid_needs_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $past(tick_i && busy_o));

    assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |=> !valid_o);

    assert_hold_output_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> $stable(ser_o));

    assert_done_after_unit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(valid_o) && !valid_o));

    assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_load_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !tick_i) |=> busy_o);

endmodule

bind imm_word_serializer imser_check #(.UNIT_MAX(UNIT_MAX)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .tick_i  (tick_i),
    .ser_o   (ser_o),
    .valid_o (valid_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/imm_word_serializer_test.sv
module imm_word_serializer_test;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        load_i = 1'b0;
    logic [31:0] data_i = '0;
    logic [16:0] mode_i = '0;
    logic        tick_i = 1'b0;
    logic [3:0]  ser_o;
    logic        valid_o, busy_o, done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5ns clk_i = ~clk_i;

    imm_word_serializer uut (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load_i),
        .data_i  (data_i),
        .mode_i  (mode_i),
        .tick_i  (tick_i),
        .ser_o   (ser_o),
        .valid_o (valid_o),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    localparam int NV = 8;
    localparam logic [31:0] V_DATA [NV] = '{
        32'h8421_F00D, 32'h8421_F00D, 32'h1234_5678, 32'h1234_5678,
        32'hA5C3_3CA5, 32'hA5C3_3CA5, 32'h0000_0001, 32'h8000_0000};
    localparam int V_CODE [NV] = '{1, 1, 2, 2, 4, 4, 1, 4};
    localparam int V_ORD  [NV] = '{0, 1, 0, 1, 0, 1, 1, 1};
    localparam int V_GAP  [NV] = '{0, 0, 1, 0, 2, 0, 0, 1};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_unit(input logic [31:0] d, input int w,
                                            input int ord, input int k);
        int per_byte = 8 / w;
        int b = k / per_byte;
        int j = k % per_byte;
        if (ord != 0) j = per_byte - 1 - j;
        return 4'((d >> (b * 8 + j * w)) & ((1 << w) - 1));
    endfunction

    function automatic int eff_width(input int code);
        return (code == 2 || code == 4) ? code : 1;
    endfunction

    task automatic run_word(input logic [31:0] d, input int code, input int ord,
                            input int gap, input string req);
        int w = eff_width(code);
        int n = 32 / w;
        logic [3:0] held;
        @(negedge clk_i);
        load_i = 1'b1;
        data_i = d;
        mode_i = {ord[0], 13'h0A5A, code[2:0]};
        @(negedge clk_i);
        // keep strobing a different word and mode while busy (R8)
        data_i = ~d;
        mode_i = {~ord[0], 13'h1F0F, 3'(code ^ 6)};
        check("R7 busy after load", {31'd0, busy_o}, 32'd1);
        for (int k = 0; k < n; k++) begin
            tick_i = 1'b1;
            @(negedge clk_i);
            tick_i = 1'b0;
            check($sformatf("R6 valid step %0d", k), {31'd0, valid_o}, 32'd1);
            check($sformatf("%s unit step %0d", req, k), {28'd0, ser_o},
                  {28'd0, exp_unit(d, w, ord, k)});
            check("R7 busy during word", {31'd0, busy_o}, (k == n - 1) ? 32'd0 : 32'd1);
            if (k != n - 1) begin
                held = ser_o;
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk_i);
                    check("R6 no valid without tick", {31'd0, valid_o}, 32'd0);
                    check("R6 output held", {28'd0, ser_o}, {28'd0, held});
                    check("R8 word kept in flight", {31'd0, busy_o}, 32'd1);
                end
            end
        end
        load_i = 1'b0;
        @(negedge clk_i);
        check("R7 done after last unit", {31'd0, done_o}, 32'd1);
        check("R7 no extra unit", {31'd0, valid_o}, 32'd0);
        @(negedge clk_i);
        check("R7 done is one cycle", {31'd0, done_o}, 32'd0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk_i);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk_i);
        check("R1 ser after reset", {28'd0, ser_o}, 32'd0);
        check("R1 valid after reset", {31'd0, valid_o}, 32'd0);
        check("R1 busy after reset", {31'd0, busy_o}, 32'd0);
        check("R1 done after reset", {31'd0, done_o}, 32'd0);
        rst_ni = 1'b1;

        // tick while idle does nothing (R6)
        @(negedge clk_i);
        tick_i = 1'b1;
        repeat (3) begin
            @(negedge clk_i);
            check("R6 idle tick valid", {31'd0, valid_o}, 32'd0);
            check("R6 idle tick busy", {31'd0, busy_o}, 32'd0);
        end
        tick_i = 1'b0;

        // vector table: R2, R3, R4, R5
        for (int v = 0; v < NV; v++) begin
            string tag;
            if (V_CODE[v] == 1) tag = (V_ORD[v] != 0) ? "R3" : "R2";
            else                tag = (V_ORD[v] != 0) ? "R5" : "R4";
            run_word(V_DATA[v], V_CODE[v], V_ORD[v], V_GAP[v], tag);
        end

        // invalid width codes fall back to single bits (R9)
        run_word(32'hDEAD_BEEF, 0, 0, 0, "R9 code0");
        run_word(32'hDEAD_BEEF, 7, 1, 0, "R9 code7");
        run_word(32'h0F1E_2D3C, 3, 0, 1, "R9 code3");

        summary();
    end

endmodule